// File: doc/BRIEF.md
# Half-Bridge Gate Protection Controller

This synchronous controller sits between two logic-level drive commands, one for the low switch and one for the high switch of a half-bridge, and the two gate-enable outputs that drive those switches. Each gate follows its own command. The gate is held off when one of three things applies: the other side still owns the bridge, a supply of that side is out of range, or an overcurrent or desaturation trip has been latched on that side. The block also drives one clamp output per side. The clamp is high while that side's gate is off, so the sense input can be shorted to its reference. A single active-low status output reports any fault on either side.

Comparator results and supply-good flags arrive as asynchronous digital levels. Each one passes through a synchronizer of `SYNC_STAGES` flops. Every output is a register, or the inverse of one, so no output can glitch. No data moves as a stream, so every pin is a plain level. Dead time must come from upstream logic. The interlock only ensures that a side cannot turn on while the opposite command is still high.

Top module: `hbp_gate_ctrl`

## Requirements
- R1: A gate output goes high exactly `SYNC_STAGES`+1 rising clock edges after its command input rises, when no other rule blocks it. It goes low the same number of edges after the command falls.
- R2: After reset, both gates stay off until all four supply-good inputs (positive and negative, low and high side) have been high together at least once.
- R3: A gate that is off may turn on only while the opposite side's command is low. A gate that is on stays on while its own command is high. The two gates are never high together.
- R4: If both commands rise in the same cycle while both gates are off, neither gate turns on. Both stay off until one command is released, and then the other side turns on.
- R5: A sense input is ignored while its side's gate is off: it sets no fault and leaves fault_n high. Each clamp output is the inverse of its side's gate.
- R6: A high sense input while that side's gate is on turns the gate off and latches an overcurrent fault on that side, `SYNC_STAGES`+1 edges after the sense input rises.
- R7: A latched overcurrent fault clears only on the next rising edge of that side's own command. The gate turns on at that same edge.
- R8: A low positive-supply or negative-supply flag for a side turns that side's gate off. The fault is not latched: it ends, and the gate returns, once the flag is high again, with no command edge needed.
- R9: fault_n is low whenever either side has a latched overcurrent fault or a supply flag low. It is high otherwise. It changes on the same edge as the gate it concerns.
- R10: A fault on one side does not turn off the other side's gate. It appears only on fault_n.
- R11: During reset both gates are low, both clamps are high, both overcurrent latches are clear and fault_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lo_cmd | input | 1 | Low-side drive command |
| hi_cmd | input | 1 | High-side drive command |
| lo_vpos_ok | input | 1 | Low-side positive supply good |
| lo_vneg_ok | input | 1 | Low-side negative supply good |
| hi_vpos_ok | input | 1 | High-side positive supply good |
| hi_vneg_ok | input | 1 | High-side negative supply good |
| lo_oc | input | 1 | Low-side overcurrent/desaturation comparator result |
| hi_oc | input | 1 | High-side overcurrent/desaturation comparator result |
| lo_gate | output | 1 | Low-side gate enable |
| hi_gate | output | 1 | High-side gate enable |
| lo_clamp | output | 1 | Low-side sense clamp, high while the low gate is off |
| hi_clamp | output | 1 | High-side sense clamp, high while the high gate is off |
| fault_n | output | 1 | Combined fault status, active low |

## Verification
Every result of this block appears a fixed three rising edges after an input change with the default two-stage synchronizer. That holds for a gate turning on or off, a clamp following its gate, an overcurrent latch being set or cleared, and fault_n changing. The bench changes inputs on a falling edge and stamps each expected result with the cycle number at which it is due, that cycle plus three. A monitor compares it on the falling edge that follows the third rising edge. The check therefore catches a result that arrives one cycle late as well as one that never arrives.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
  localparam int unsigned NUM_SIDES = 2;
  localparam int unsigned IDX_LO    = 0;
  localparam int unsigned IDX_HI    = 1;

  typedef struct packed {
    logic cmd;
    logic vpos_ok;
    logic vneg_ok;
    logic oc;
  } side_in_t;

  localparam int unsigned SIDE_IN_W = $bits(side_in_t);
endpackage

// File: rtl/hbp_sync.sv
module hbp_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < int'(STAGES); s++) chain[s] <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < int'(STAGES); s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hbp_interlock.sv
module hbp_interlock #(
  parameter int unsigned NUM = 2
) (
  input  logic [NUM-1:0] cmd_i,
  input  logic [NUM-1:0] gate_i,
  output logic [NUM-1:0] permit_o
);
  // A side keeps ownership while on; otherwise it may start only when
  // every other command is released.
  for (genvar i = 0; i < int'(NUM); i++) begin : g_permit
    localparam logic [NUM-1:0] SELF = NUM'(1) << i;
    assign permit_o[i] = gate_i[i] | ~(|(cmd_i & ~SELF));
  end
endmodule

// File: rtl/hbp_side.sv
module hbp_side (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_i,
  input  logic vpos_ok_i,
  input  logic vneg_ok_i,
  input  logic oc_i,
  input  logic armed_i,
  input  logic permit_i,
  output logic gate_o,
  output logic oc_latch_o,
  output logic oc_next_o,
  output logic uv_o
);
  logic cmd_d, gate_q, oc_q;
  logic rise, oc_set, oc_d, sup_ok, gate_d;

  always_comb begin
    sup_ok = vpos_ok_i & vneg_ok_i;
    rise   = cmd_i & ~cmd_d;
    oc_set = gate_q & oc_i;               // sense honoured only while on
    oc_d   = oc_set | (oc_q & ~rise);     // own command edge clears
    gate_d = cmd_i & permit_i & armed_i & sup_ok & ~oc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_d  <= 1'b0;
      gate_q <= 1'b0;
      oc_q   <= 1'b0;
    end else begin
      cmd_d  <= cmd_i;
      gate_q <= gate_d;
      oc_q   <= oc_d;
    end
  end

  assign gate_o     = gate_q;
  assign oc_latch_o = oc_q;
  assign oc_next_o  = oc_d;
  assign uv_o       = ~sup_ok;

  AST_OC_KILLS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    gate_q && oc_i |=> !gate_q && oc_q); // R6
  AST_OC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    oc_q && !(cmd_i && !cmd_d) |=> oc_q); // R7
  AST_SENSE_IGNORED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !oc_q && !gate_q |=> !oc_q); // R5
  AST_UV_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    !(vpos_ok_i && vneg_ok_i) |=> !gate_q); // R8
  AST_UNARMED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_i |=> !gate_q); // R2
endmodule

// File: rtl/hbp_gate_ctrl.sv
module hbp_gate_ctrl
  import hbp_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lo_cmd,
  input  logic hi_cmd,
  input  logic lo_vpos_ok,
  input  logic lo_vneg_ok,
  input  logic hi_vpos_ok,
  input  logic hi_vneg_ok,
  input  logic lo_oc,
  input  logic hi_oc,
  output logic lo_gate,
  output logic hi_gate,
  output logic lo_clamp,
  output logic hi_clamp,
  output logic fault_n
);
  localparam int unsigned FLAT_W = NUM_SIDES * SIDE_IN_W;

  side_in_t              raw_in [NUM_SIDES];
  side_in_t              syn_in [NUM_SIDES];
  logic [FLAT_W-1:0]     raw_flat, syn_flat;
  logic [NUM_SIDES-1:0]  cmd_vec, gate_vec, permit_vec;
  logic [NUM_SIDES-1:0]  oc_latch_vec, oc_next_vec, uv_vec;
  logic                  armed_q, armed, fault_n_q;

  assign raw_in[IDX_LO] = '{cmd: lo_cmd, vpos_ok: lo_vpos_ok, vneg_ok: lo_vneg_ok, oc: lo_oc};
  assign raw_in[IDX_HI] = '{cmd: hi_cmd, vpos_ok: hi_vpos_ok, vneg_ok: hi_vneg_ok, oc: hi_oc};

  for (genvar i = 0; i < int'(NUM_SIDES); i++) begin : g_pack
    assign raw_flat[i*SIDE_IN_W +: SIDE_IN_W] = raw_in[i];
    assign syn_in[i] = side_in_t'(syn_flat[i*SIDE_IN_W +: SIDE_IN_W]);
    assign cmd_vec[i] = syn_in[i].cmd;
  end

  hbp_sync #(.WIDTH(FLAT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_flat), .q(syn_flat)
  );

  hbp_interlock #(.NUM(NUM_SIDES)) u_interlock (
    .cmd_i(cmd_vec), .gate_i(gate_vec), .permit_o(permit_vec)
  );

  // Arming: all supplies have been good together once since reset.
  assign armed = armed_q | ~(|uv_vec);

  for (genvar i = 0; i < int'(NUM_SIDES); i++) begin : g_side
    hbp_side u_side (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_i     (syn_in[i].cmd),
      .vpos_ok_i (syn_in[i].vpos_ok),
      .vneg_ok_i (syn_in[i].vneg_ok),
      .oc_i      (syn_in[i].oc),
      .armed_i   (armed),
      .permit_i  (permit_vec[i]),
      .gate_o    (gate_vec[i]),
      .oc_latch_o(oc_latch_vec[i]),
      .oc_next_o (oc_next_vec[i]),
      .uv_o      (uv_vec[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      fault_n_q <= 1'b1;
    end else begin
      armed_q   <= armed;
      fault_n_q <= ~(|oc_next_vec | |uv_vec);
    end
  end

  assign lo_gate  = gate_vec[IDX_LO];
  assign hi_gate  = gate_vec[IDX_HI];
  assign lo_clamp = ~gate_vec[IDX_LO];
  assign hi_clamp = ~gate_vec[IDX_HI];
  assign fault_n  = fault_n_q;

  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hi_gate, lo_gate})); // R3
  AST_SIMUL_RISE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_vec[IDX_LO]) && $rose(cmd_vec[IDX_HI]) |=> !lo_gate && !hi_gate); // R4
  AST_FAULT_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
    (|oc_latch_vec) |-> !fault_n); // R9
  AST_UV_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
    (|uv_vec) |=> !fault_n); // R9
endmodule

// File: tb/hbp_gate_ctrl_tb.sv
module hbp_gate_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LATENCY    = 3;
  localparam int WATCHDOG   = 20000;

  typedef struct {
    int    due;
    logic  lo;
    logic  hi;
    logic  fn;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lo_cmd = 0, hi_cmd = 0;
  logic lo_vpos_ok = 0, lo_vneg_ok = 0, hi_vpos_ok = 0, hi_vneg_ok = 0;
  logic lo_oc = 0, hi_oc = 0;
  logic lo_gate, hi_gate, lo_clamp, hi_clamp, fault_n;

  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hbp_gate_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .lo_cmd(lo_cmd), .hi_cmd(hi_cmd),
    .lo_vpos_ok(lo_vpos_ok), .lo_vneg_ok(lo_vneg_ok),
    .hi_vpos_ok(hi_vpos_ok), .hi_vneg_ok(hi_vneg_ok),
    .lo_oc(lo_oc), .hi_oc(hi_oc),
    .lo_gate(lo_gate), .hi_gate(hi_gate),
    .lo_clamp(lo_clamp), .hi_clamp(hi_clamp),
    .fault_n(fault_n)
  );

  task automatic compare(input logic lo, input logic hi, input logic fn, input string req);
    logic [4:0] act, want;
    act  = {lo_gate, hi_gate, lo_clamp, hi_clamp, fault_n};
    want = {lo, hi, ~lo, ~hi, fn};
    checks++;
    if (act !== want) begin
      errors++;
      $display("FAIL %s: {lo_gate,hi_gate,lo_clamp,hi_clamp,fault_n} actual %b expected %b",
               req, act, want);
    end
  endtask

  // Driver side: inputs were just changed on a falling edge.
  task automatic expect_due(input logic lo, input logic hi, input logic fn, input string req);
    exp_t e;
    e.due = cyc + LATENCY; e.lo = lo; e.hi = hi; e.fn = fn; e.req = req;
    sb.push_back(e);
    repeat (LATENCY + 1) @(negedge clk);
  endtask

  // Monitor side.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      compare(e.lo, e.hi, e.fn, e.req);
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare(1'b0, 1'b0, 1'b1, "R11 reset state");
    rst_n = 1'b1;
    @(negedge clk);

    // R2: only low-side supplies good, not yet armed
    lo_vpos_ok = 1; lo_vneg_ok = 1; lo_cmd = 1;
    expect_due(0, 0, 0, "R2 unarmed gate held off");
    hi_vpos_ok = 1; hi_vneg_ok = 1;
    expect_due(1, 0, 1, "R2 R1 armed, low gate follows command");

    // R3 interlock
    hi_cmd = 1;
    expect_due(1, 0, 1, "R3 high blocked while low owns");
    lo_cmd = 0;
    expect_due(0, 1, 1, "R3 handover on low release");
    hi_cmd = 0;
    expect_due(0, 0, 1, "R1 high gate follows command low");

    // R4 simultaneous rise
    lo_cmd = 1; hi_cmd = 1;
    expect_due(0, 0, 1, "R4 simultaneous rise blocks both");
    lo_cmd = 0;
    expect_due(0, 1, 1, "R4 high turns on after low released");
    hi_cmd = 0;
    expect_due(0, 0, 1, "R1 all off");

    // R5 sense ignored while off
    lo_oc = 1; hi_oc = 1;
    expect_due(0, 0, 1, "R5 sense ignored while gates off");
    lo_oc = 0; hi_oc = 0;
    expect_due(0, 0, 1, "R5 no fault latched while off");

    // R6/R7 low side overcurrent
    lo_cmd = 1;
    expect_due(1, 0, 1, "R1 low gate on");
    lo_oc = 1;
    expect_due(0, 0, 0, "R6 low overcurrent trips gate");
    lo_oc = 0;
    expect_due(0, 0, 0, "R7 latch held with command still high");
    lo_cmd = 0;
    expect_due(0, 0, 0, "R7 latch held on command fall");
    lo_cmd = 1;
    expect_due(1, 0, 1, "R7 rising command clears latch");

    // R8 undervoltage, non-latching
    lo_vneg_ok = 0;
    expect_due(0, 0, 0, "R8 low negative supply bad");
    lo_vneg_ok = 1;
    expect_due(1, 0, 1, "R8 recovers without command edge");
    lo_vpos_ok = 0;
    expect_due(0, 0, 0, "R8 low positive supply bad");
    lo_vpos_ok = 1;
    expect_due(1, 0, 1, "R8 positive supply restored");

    // R10 high-side undervoltage does not touch low gate
    hi_vneg_ok = 0;
    expect_due(1, 0, 0, "R10 R9 high supply fault, low stays on");
    hi_vneg_ok = 1;
    expect_due(1, 0, 1, "R9 fault_n released");

    // High side overcurrent
    lo_cmd = 0; hi_cmd = 1;
    expect_due(0, 1, 1, "R1 high gate on");
    hi_oc = 1;
    expect_due(0, 0, 0, "R6 high overcurrent trips gate");
    hi_oc = 0; hi_cmd = 0;
    expect_due(0, 0, 0, "R7 high latch held");
    lo_cmd = 1;
    expect_due(1, 0, 0, "R10 low gate runs during high fault");
    lo_cmd = 0;
    expect_due(0, 0, 0, "R9 fault_n still low");
    hi_cmd = 1;
    expect_due(0, 1, 1, "R7 high rising command clears latch");
    hi_vpos_ok = 0;
    expect_due(0, 0, 0, "R8 high positive supply bad");
    hi_vpos_ok = 1;
    expect_due(0, 1, 1, "R8 high recovers");
    hi_cmd = 0;
    expect_due(0, 0, 1, "R1 final off");

    repeat (2) @(negedge clk);
    if (sb.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule